// File: doc/BRIEF.md
# Uniform and Affine Vector Detector

This block sits on the write path of a SIMT register file and decides, for each vector that is written, whether the vector can be held in compact form. A vector carries one 32-bit element for each of the 32 threads of a warp. When every lane holds the same value the vector is uniform. When each lane exceeds its lower neighbour by one fixed amount the vector is affine. Either kind can be stored as a (base, stride) pair in place of 32 words. Uniform vectors are the affine vectors whose stride is zero.

A write is presented with a valid strobe. One clock later the block reports the class of the vector and, for a compressible vector, the pair that stands for it. A mode input limits a write to uniform detection. A parameter builds an instance that can only ever report uniform, for register files whose contents gain nothing from a stride. A second, purely combinational path expands a (base, stride) pair back into the full 32-lane vector, so that a compact register can be read out.

Top module: `vec_affine_classifier`

## Requirements
- R1: While reset is held and right after it, cls_valid, is_uniform and is_affine are 0, and base and stride are 0.
- R2: cls_valid is 1 in exactly the cycle after a cycle with wr_valid = 1 at a rising clock edge, and 0 otherwise.
- R3: When all lanes of the written vector are equal, is_uniform = 1, is_affine = 1, stride = 0 and base = lane 0. Lane i sits at bits [32*i+31 : 32*i] of wr_lanes.
- R4: When lane i equals lane0 + i*(lane1 - lane0) for every lane, the stride is non-zero, affine detection is enabled and the mode is clear, then is_affine = 1, is_uniform = 0, base = lane 0 and stride = lane1 - lane0.
- R5: A vector that is neither uniform nor affine gives is_uniform = 0, is_affine = 0, stride = 0 and base = lane 0. A single lane out of pattern, lane 0 or lane 31 included, is enough.
- R6: The affine test uses arithmetic modulo 2^32, so strides that are negative in two's complement and sequences that wrap past 0xFFFFFFFF are reported as affine.
- R7: With uniform_only = 1 during the write, an affine non-uniform vector is reported with is_affine = 0, is_uniform = 0 and stride = 0; uniform vectors are still reported as uniform.
- R8: An instance built with AFFINE_CAPABLE = 0 reports is_affine only together with is_uniform, whatever the mode input.
- R9: In cycles without a write, is_uniform, is_affine, base and stride keep the values of the last write, whatever wr_lanes carries.
- R10: exp_lanes lane i equals exp_base + i*exp_stride modulo 2^32, in the same cycle its inputs are presented, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A vector is written this cycle |
| uniform_only | input | 1 | Limit this write to uniform detection |
| wr_lanes | input | 1024 | Written vector, lane i at bits 32*i+31 : 32*i |
| cls_valid | output | 1 | Classification of the previous cycle's write is shown |
| is_uniform | output | 1 | Last written vector had all lanes equal |
| is_affine | output | 1 | Last written vector is compressible (uniform included) |
| base | output | 32 | Lane 0 of the last written vector |
| stride | output | 32 | Lane step of a compressible non-uniform vector, else 0 |
| exp_base | input | 32 | Base of a pair to expand |
| exp_stride | input | 32 | Stride of a pair to expand |
| exp_lanes | output | 1024 | Expanded vector, lane i = base + i*stride |

## Verification
The only state is the registered result, so a fault there shows at the ports one cycle after the write that caused it: a wrong flag, a stride left non-zero on a rejected vector, or a pulse of cls_valid that lasts too long. A lost hold shows in the first idle cycle as base or stride tracking the idle bus. Errors in the lane comparison show as misclassification only for patterns that break at one lane, so vectors broken at lane 0, at lane 31 and in the middle are written alongside random and wrapping sequences. The expansion path has no state, and any fault in it appears at once on some lane of exp_lanes.

// File: rtl/vaff_pkg.sv
package vaff_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  valid;
        logic  uni;
        logic  aff;
        word_t base;
        word_t stride;
    } cls_state_t;

    localparam cls_state_t CLS_RESET = '{
        valid:  1'b0,
        uni:    1'b0,
        aff:    1'b0,
        base:   '0,
        stride: '0
    };

endpackage

// File: rtl/vaff_expander.sv
// Builds a full lane vector from a (base, stride) pair: lane i = base + i*stride.
module vaff_expander
    import vaff_pkg::*;
#(
    parameter int LANES = 32
) (
    input  word_t                    seed_base,
    input  word_t                    seed_stride,
    output logic [LANES*WORD_W-1:0]  lanes_out
);

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        localparam int LI = gi;
        word_t step_sum;
        always_comb begin
            step_sum = seed_base + (word_t'(LI) * seed_stride);
        end
        assign lanes_out[gi*WORD_W +: WORD_W] = step_sum;
    end

endmodule

// File: rtl/vaff_compare.sv
// Compares the written lanes against lane 0 and against a predicted sequence.
module vaff_compare
    import vaff_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [LANES*WORD_W-1:0] obs_lanes,
    input  logic [LANES*WORD_W-1:0] pred_lanes,
    output logic                    all_same,
    output logic                    all_fit
);

    localparam int LAST = LANES - 1;

    logic [LANES-1:0] diff_lane0;
    logic [LANES-1:0] diff_pred;
    word_t            head;

    assign head = obs_lanes[0 +: WORD_W];

    for (genvar gi = 0; gi < LANES; gi++) begin : g_cmp
        word_t obs_w;
        word_t pred_w;
        assign obs_w  = obs_lanes[gi*WORD_W +: WORD_W];
        assign pred_w = pred_lanes[gi*WORD_W +: WORD_W];
        always_comb begin
            diff_lane0[gi] = (obs_w != head);
            diff_pred[gi]  = (obs_w != pred_w);
        end
    end

    always_comb begin
        all_same = ~|diff_lane0[LAST:0];
        all_fit  = ~|diff_pred[LAST:0];
    end

endmodule

// File: rtl/vec_affine_classifier.sv
// Classifies written vectors as uniform / affine / neither and expands pairs.
module vec_affine_classifier
    import vaff_pkg::*;
#(
    parameter int LANES          = 32,
    parameter bit AFFINE_CAPABLE = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    input  logic                    uniform_only,
    input  logic [LANES*WORD_W-1:0] wr_lanes,
    output logic                    cls_valid,
    output logic                    is_uniform,
    output logic                    is_affine,
    output logic [WORD_W-1:0]       base,
    output logic [WORD_W-1:0]       stride,
    input  logic [WORD_W-1:0]       exp_base,
    input  logic [WORD_W-1:0]       exp_stride,
    output logic [LANES*WORD_W-1:0] exp_lanes
);

    localparam int VEC_W = LANES * WORD_W;

    word_t            lane0_w;
    word_t            lane1_w;
    word_t            cand_stride;
    logic [VEC_W-1:0] probe_lanes;
    logic             cmp_same;
    logic             cmp_fit;
    logic             affine_en;
    cls_state_t       st_d;
    cls_state_t       st_q;

    assign lane0_w     = wr_lanes[0 +: WORD_W];
    assign lane1_w     = wr_lanes[WORD_W +: WORD_W];
    assign cand_stride = lane1_w - lane0_w;

    // Predicted sequence from the first two lanes
    vaff_expander #(.LANES(LANES)) u_probe (
        .seed_base   (lane0_w),
        .seed_stride (cand_stride),
        .lanes_out   (probe_lanes)
    );

    vaff_compare #(.LANES(LANES)) u_cmp (
        .obs_lanes  (wr_lanes),
        .pred_lanes (probe_lanes),
        .all_same   (cmp_same),
        .all_fit    (cmp_fit)
    );

    // Read-side expansion path
    vaff_expander #(.LANES(LANES)) u_expand (
        .seed_base   (exp_base),
        .seed_stride (exp_stride),
        .lanes_out   (exp_lanes)
    );

    always_comb begin
        affine_en = AFFINE_CAPABLE && !uniform_only;
        st_d      = st_q;
        st_d.valid = wr_valid;
        if (wr_valid) begin
            st_d.uni    = cmp_same;
            st_d.aff    = cmp_same || (cmp_fit && affine_en);
            st_d.base   = lane0_w;
            st_d.stride = (!cmp_same && cmp_fit && affine_en) ? cand_stride : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CLS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cls_valid  = st_q.valid;
    assign is_uniform = st_q.uni;
    assign is_affine  = st_q.aff;
    assign base       = st_q.base;
    assign stride     = st_q.stride;

endmodule

// File: rtl/vaff_checker.sv
module vaff_checker
    import vaff_pkg::*;
#(
    parameter int LANES          = 32,
    parameter bit AFFINE_CAPABLE = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_valid,
    input logic                    uniform_only,
    input logic                    cls_valid,
    input logic                    is_uniform,
    input logic                    is_affine,
    input logic [WORD_W-1:0]       base,
    input logic [WORD_W-1:0]       stride,
    input logic [WORD_W-1:0]       exp_base,
    input logic [WORD_W-1:0]       exp_stride,
    input logic [LANES*WORD_W-1:0] exp_lanes
);

    a_r2_valid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> cls_valid);

    a_r2_no_valid_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !cls_valid);

    a_r3_uniform_is_affine: assert property (@(posedge clk) disable iff (!rst_n)
        is_uniform |-> (is_affine && stride == '0));

    a_r5_reject_zero_stride: assert property (@(posedge clk) disable iff (!rst_n)
        !is_affine |-> (stride == '0));

    a_r7_mode_uniform_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && uniform_only) |=> (is_affine == is_uniform));

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> ($stable(base) && $stable(stride) && $stable(is_affine) && $stable(is_uniform)));

    a_r10_expand_lane1: assert property (@(posedge clk) disable iff (!rst_n)
        exp_lanes[WORD_W +: WORD_W] == exp_base + exp_stride);

    if (!AFFINE_CAPABLE) begin : g_meta
        a_r8_meta_never_affine: assert property (@(posedge clk) disable iff (!rst_n)
            is_affine |-> is_uniform);
    end

endmodule

bind vec_affine_classifier vaff_checker #(
    .LANES          (LANES),
    .AFFINE_CAPABLE (AFFINE_CAPABLE)
) u_vaff_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .uniform_only (uniform_only),
    .cls_valid    (cls_valid),
    .is_uniform   (is_uniform),
    .is_affine    (is_affine),
    .base         (base),
    .stride       (stride),
    .exp_base     (exp_base),
    .exp_stride   (exp_stride),
    .exp_lanes    (exp_lanes)
);

// File: tb/vec_affine_classifier_test.sv
`timescale 1ns/1ps
module vec_affine_classifier_test;

    localparam int NL = 32;
    localparam int W  = 32;

    typedef logic [NL*W-1:0] vec_t;
    typedef logic [W-1:0]    w_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic uniform_only = 1'b0;
    vec_t wr_lanes = '0;
    w_t   exp_base = '0;
    w_t   exp_stride = '0;

    logic cls_valid, is_uniform, is_affine;
    w_t   base, stride;
    vec_t exp_lanes;
    logic m_valid, m_uni, m_aff;
    w_t   m_base, m_stride;
    vec_t m_exp;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    vec_affine_classifier #(.LANES(NL), .AFFINE_CAPABLE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .uniform_only(uniform_only),
        .wr_lanes(wr_lanes), .cls_valid(cls_valid), .is_uniform(is_uniform),
        .is_affine(is_affine), .base(base), .stride(stride),
        .exp_base(exp_base), .exp_stride(exp_stride), .exp_lanes(exp_lanes));

    vec_affine_classifier #(.LANES(NL), .AFFINE_CAPABLE(1'b0)) uut_meta (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .uniform_only(uniform_only),
        .wr_lanes(wr_lanes), .cls_valid(m_valid), .is_uniform(m_uni),
        .is_affine(m_aff), .base(m_base), .stride(m_stride),
        .exp_base(exp_base), .exp_stride(exp_stride), .exp_lanes(m_exp));

    function automatic w_t lane_of(vec_t v, int i);
        return v[i*W +: W];
    endfunction

    function automatic vec_t make_seq(w_t b, w_t s);
        vec_t v;
        for (int i = 0; i < NL; i++) v[i*W +: W] = b + w_t'(i) * s;
        return v;
    endfunction

    // Expected classification from the requirement text
    function automatic logic [1+1+W+W-1:0] model(vec_t v, logic uo, logic cap);
        logic uni, fit, aff;
        w_t s, st;
        uni = 1'b1; fit = 1'b1;
        s = lane_of(v, 1) - lane_of(v, 0);
        for (int i = 0; i < NL; i++) begin
            if (lane_of(v, i) != lane_of(v, 0)) uni = 1'b0;
            if (lane_of(v, i) != lane_of(v, 0) + w_t'(i) * s) fit = 1'b0;
        end
        aff = uni | (fit & cap & ~uo);
        st  = (aff && !uni) ? s : '0;
        return {uni, aff, lane_of(v, 0), st};
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_and_check(string req, vec_t v, logic uo);
        logic [1+1+W+W-1:0] e, em;
        @(negedge clk);
        wr_lanes = v; uniform_only = uo; wr_valid = 1'b1;
        e  = model(v, uo, 1'b1);
        em = model(v, uo, 1'b0);
        @(posedge clk); #2;
        wr_valid = 1'b0;
        chk("R2", "cls_valid", 64'(cls_valid), 64'd1);
        chk(req, "is_uniform", 64'(is_uniform), 64'(e[2*W+1]));
        chk(req, "is_affine",  64'(is_affine),  64'(e[2*W]));
        chk(req, "base",       64'(base),       64'(e[2*W-1:W]));
        chk(req, "stride",     64'(stride),     64'(e[W-1:0]));
        chk("R8", "meta is_uniform", 64'(m_uni),    64'(em[2*W+1]));
        chk("R8", "meta is_affine",  64'(m_aff),    64'(em[2*W]));
        chk("R8", "meta stride",     64'(m_stride), 64'(em[W-1:0]));
    endtask

    task automatic check_expand(w_t b, w_t s);
        vec_t e;
        logic bad;
        exp_base = b; exp_stride = s;
        #1;
        e = make_seq(b, s);
        bad = 1'b0;
        for (int i = 0; i < NL; i++) begin
            if (lane_of(exp_lanes, i) !== lane_of(e, i)) begin
                bad = 1'b1;
                $display("FAIL R10 lane %0d: actual=%h expected=%h", i, lane_of(exp_lanes, i), lane_of(e, i));
            end
        end
        checks++;
        if (bad) errors++;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        vec_t v;
        w_t   b, s, hb, hs;
        logic hu, ha;
        int   kind;
        void'($urandom(32'd1234));

        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1", "cls_valid",  64'(cls_valid),  64'd0);
        chk("R1", "is_uniform", 64'(is_uniform), 64'd0);
        chk("R1", "is_affine",  64'(is_affine),  64'd0);
        chk("R1", "base",       64'(base),       64'd0);
        chk("R1", "stride",     64'(stride),     64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1", "cls_valid after release", 64'(cls_valid), 64'd0);

        // Directed corner cases
        write_and_check("R3", make_seq(32'hDEAD_BEEF, 32'd0), 1'b0);
        write_and_check("R4", make_seq(32'd100, 32'd7), 1'b0);
        write_and_check("R6", make_seq(32'd5, 32'hFFFF_FFFF), 1'b0);
        write_and_check("R6", make_seq(32'hFFFF_FFF0, 32'h0000_0003), 1'b0);
        v = make_seq(32'd10, 32'd4); v[31*W +: W] = v[31*W +: W] + 1;
        write_and_check("R5", v, 1'b0);
        v = make_seq(32'd10, 32'd4); v[0 +: W] = 32'd11;
        write_and_check("R5", v, 1'b0);
        v = make_seq(32'd77, 32'd0); v[17*W +: W] = 32'd78;
        write_and_check("R5", v, 1'b0);
        write_and_check("R7", make_seq(32'd1, 32'd2), 1'b1);
        write_and_check("R7", make_seq(32'h1234, 32'd0), 1'b1);
        write_and_check("R8", make_seq(32'd40, 32'd8), 1'b0);

        // R2: pulse lasts one cycle
        @(posedge clk); #2;
        chk("R2", "cls_valid drops", 64'(cls_valid), 64'd0);

        // R9: hold across idle cycles with a changing bus
        write_and_check("R4", make_seq(32'd3, 32'd9), 1'b0);
        hu = is_uniform; ha = is_affine; hb = base; hs = stride;
        @(negedge clk);
        wr_lanes = make_seq(32'h5555, 32'd0); uniform_only = 1'b1;
        @(posedge clk); #2;
        chk("R9", "is_uniform held", 64'(is_uniform), 64'(hu));
        chk("R9", "is_affine held",  64'(is_affine),  64'(ha));
        chk("R9", "base held",       64'(base),       64'(hb));
        chk("R9", "stride held",     64'(stride),     64'(hs));
        chk("R2", "no valid when idle", 64'(cls_valid), 64'd0);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            kind = int'($urandom_range(0, 3));
            b = $urandom; s = $urandom;
            case (kind)
                0: v = make_seq(b, '0);
                1: v = make_seq(b, s);
                2: for (int i = 0; i < NL; i++) v[i*W +: W] = $urandom;
                default: begin
                    v = make_seq(b, s);
                    v[$urandom_range(0, NL-1)*W +: W] ^= 32'h0000_0100;
                end
            endcase
            write_and_check(kind == 0 ? "R3" : kind == 1 ? "R4" : "R5", v, logic'($urandom_range(0, 1)));
        end

        // R10: expansion path
        check_expand(32'd0, 32'd1);
        check_expand(32'hFFFF_FFFE, 32'h8000_0001);
        for (int n = 0; n < 20; n++) check_expand($urandom, $urandom);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule